// File: doc/BRIEF.md
# SPI Flash Memory-Window Read Engine

This block turns a memory-bus read of a flash chip window into one complete single-lane SPI transaction. When a request is accepted, the engine selects the addressed chip, shifts out a command byte, the read address and any dummy bytes, clocks in one, two or four data bytes, and then deselects the chip. The data is returned on a 32-bit read bus with a one-cycle done pulse.

The transaction is configured entirely by fields of a per-chip control word and by a per-chip address-length bit. The control word supplies the command byte, the read mode (plain read or fast read), a three-bit dummy-byte count held in two separate groups of bits, and the minimum deselect time. Because the engine holds back the next request until that deselect time has passed, the system bus can issue reads back to back without knowing about flash timing.

Top module: `flash_rd_engine`

## Requirements
- R1: While and after reset, with no request, every chip select is high, `spiSclk` and `spiMosi` are low, `rdDone` is low and `reqReady` is high.
- R2: A request is taken on a clock edge where `reqValid` and `reqReady` are both high. Only `spiCsN[reqCs]` goes low, and it stays low for the whole transaction. `spiSclk` idles low and runs at half the clock rate. `spiMosi` changes only while `spiSclk` is low, and `spiMiso` is sampled on each rising `spiSclk` edge.
- R3: The first byte sent is bits 23:16 of the selected chip's control word. Each byte goes out most significant bit first.
- R4: The address bytes follow the command byte, most significant byte first. If bit `reqCs` of `addrFourByte` is set, all 32 offset bits are sent as 4 bytes. Otherwise only offset bits 23:0 are sent, as 3 bytes.
- R5: When control bits 1:0 equal 1 (fast read), the dummy-byte count is {bit 14, bits 7:6}, a value from 0 to 7. Each dummy byte is 8 clocks of 0x00 on `spiMosi`. For any other value of bits 1:0, no dummy bytes are sent, whatever those count bits hold.
- R6: The `reqSize` code selects the number of data bytes: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 give 4 bytes. `spiMosi` is 0 while data bytes are clocked.
- R7: The first data byte received appears in `rdData[7:0]`, the second in bits 15:8, and so on. Byte lanes that were not read are zero.
- R8: `rdDone` is a one-cycle pulse in the cycle after the last falling `spiSclk` edge. In that same cycle chip select returns high and `rdData` holds the result.
- R9: Let N = 16 minus control bits 27:24, so a field value of 0 gives N = 16. After a transaction `reqReady` stays low, and with a request waiting, chip select stays high for exactly N+1 clocks before the next transaction starts.
- R10: Bits clocked in during the command, address and dummy bytes never reach `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctlRegs | input | NUM_CS*32 | Control words, one per chip select; chip c occupies bits [32c+31:32c] |
| addrFourByte | input | NUM_CS | Per chip select: 1 means 4-byte addressing, 0 means 3-byte |
| reqValid | input | 1 | Read request |
| reqCs | input | CS_W | Chip select addressed by the request |
| reqOffset | input | 32 | Byte offset sent as the flash address |
| reqSize | input | 2 | Size code: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes |
| reqReady | output | 1 | Engine can take a request |
| rdData | output | 32 | Read result, first received byte in the low lane |
| rdDone | output | 1 | One-cycle completion pulse |
| spiCsN | output | NUM_CS | Chip selects, active low |
| spiSclk | output | 1 | SPI clock |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
Assertions check on every cycle the properties that do not depend on a particular request:
- At most one chip select is active.
- The serial clock is quiet while deselected and toggles on every cycle of a transfer.
- The done pulse is one cycle wide, coincides with deselection and is followed by a not-ready cycle.
- A data byte is captured only after a sample.

The bench's scenarios are needed for everything that depends on the configuration:
- The byte stream each control word and address-length bit should produce, including the split dummy count and the count being ignored outside fast-read mode.
- The lane placement of the returned bytes.
- The exact deselect length for several field values.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  localparam int CTL_W        = 32;
  localparam int ADDR_W       = 32;
  localparam int DATA_BYTES   = 4;
  localparam int DATA_W       = 8 * DATA_BYTES;
  localparam int CMD_W        = 8 + ADDR_W;
  localparam int CNT_W        = 5;
  localparam int GAP_W        = 4;

  localparam int OPC_LSB      = 16;
  localparam int DUMMY_HI_BIT = 14;
  localparam int DUMMY_LO_LSB = 6;
  localparam int GAP_LSB      = 24;
  localparam int MODE_LSB     = 0;

  localparam logic [1:0] MODE_FAST = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_GAP
  } engState_t;

  typedef struct packed {
    logic       start;
    logic       sampleBit;
    logic       shiftBit;
    logic       captureByte;
    logic [1:0] lane;
  } dpStrobes_t;

endpackage

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CS_W   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        selMode,
  input  logic [2:0]        selDummy,
  input  logic [GAP_W-1:0]  selGap,
  input  logic              selFour,
  output logic              reqReady,
  output logic              spiSclk,
  output logic [NUM_CS-1:0] spiCsN,
  output logic              rdDone,
  output dpStrobes_t        strb
);

  localparam logic [GAP_W:0] GAP_FULL = (GAP_W+1)'(1 << GAP_W);

  engState_t        state;
  logic             phase;
  logic [2:0]       bitCnt;
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] dataStart;
  logic [CNT_W-1:0] lastByte;
  logic [GAP_W:0]   gapCnt;
  logic             sclk;
  logic [NUM_CS-1:0] csN;
  logic             done;

  logic [CNT_W-1:0] addrLen;
  logic [CNT_W-1:0] dummyLen;
  logic [CNT_W-1:0] dataLen;
  logic [CNT_W-1:0] hdrLen;
  logic [GAP_W:0]   gapLen;
  logic [NUM_CS-1:0] csDec;
  logic [CNT_W-1:0] laneFull;
  logic             accept;

  always_comb begin
    addrLen  = selFour ? CNT_W'(4) : CNT_W'(3);
    dummyLen = (selMode == MODE_FAST) ? CNT_W'(selDummy) : '0;
    unique case (reqSize)
      2'd0:    dataLen = CNT_W'(1);
      2'd1:    dataLen = CNT_W'(2);
      default: dataLen = CNT_W'(DATA_BYTES);
    endcase
    hdrLen = CNT_W'(1) + addrLen + dummyLen;
    gapLen = GAP_FULL - {1'b0, selGap};
    csDec  = ~(NUM_CS'(1) << reqCs);
  end

  assign accept   = (state == ST_IDLE) && reqValid;
  assign laneFull = byteCnt - dataStart;

  always_comb begin
    strb.start       = accept;
    strb.sampleBit   = (state == ST_XFER) && !phase;
    strb.shiftBit    = (state == ST_XFER) && phase;
    strb.captureByte = (state == ST_XFER) && phase && (bitCnt == 3'd7) &&
                       (byteCnt >= dataStart);
    strb.lane        = laneFull[1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= 1'b0;
      bitCnt    <= '0;
      byteCnt   <= '0;
      dataStart <= '0;
      lastByte  <= '0;
      gapCnt    <= '0;
      sclk      <= 1'b0;
      csN       <= '1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state     <= ST_XFER;
            phase     <= 1'b0;
            bitCnt    <= '0;
            byteCnt   <= '0;
            dataStart <= hdrLen;
            lastByte  <= hdrLen + dataLen - CNT_W'(1);
            gapCnt    <= gapLen;
            csN       <= csDec;
          end
        end
        ST_XFER: begin
          if (!phase) begin
            sclk  <= 1'b1;
            phase <= 1'b1;
          end else begin
            sclk   <= 1'b0;
            phase  <= 1'b0;
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              if (byteCnt == lastByte) begin
                state <= ST_GAP;
                csN   <= '1;
                done  <= 1'b1;
              end else begin
                byteCnt <= byteCnt + CNT_W'(1);
              end
            end
          end
        end
        ST_GAP: begin
          if (gapCnt <= (GAP_W+1)'(1)) state <= ST_IDLE;
          else                         gapCnt <= gapCnt - (GAP_W+1)'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign spiSclk  = sclk;
  assign spiCsN   = csN;
  assign rdDone   = done;

  p_single_cs_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~spiCsN));

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (&spiCsN) |-> !spiSclk);

  p_sclk_toggle_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_XFER) && $past(state == ST_XFER)) |-> (spiSclk != $past(spiSclk)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone);

  p_done_desel_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> (&spiCsN));

  p_gap_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> !reqReady);

endmodule

// File: rtl/flash_rd_datapath.sv
module flash_rd_datapath
  import flash_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [7:0]        opcode,
  input  logic              fourByte,
  input  logic [ADDR_W-1:0] offset,
  input  logic              spiMiso,
  output logic              spiMosi,
  output logic [DATA_W-1:0] rdData
);

  logic [CMD_W-1:0]  cmdShift;
  logic [7:0]        rxByte;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdShift <= '0;
    end else if (strb.start) begin
      cmdShift <= fourByte ? {opcode, offset} : {opcode, offset[23:0], 8'h00};
    end else if (strb.shiftBit) begin
      cmdShift <= {cmdShift[CMD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rxByte <= '0;
    else if (strb.sampleBit) rxByte <= {rxByte[6:0], spiMiso};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strb.start) begin
      dataReg <= '0;
    end else if (strb.captureByte) begin
      for (int i = 0; i < DATA_BYTES; i++) begin
        if (strb.lane == 2'(i)) dataReg[i*8 +: 8] <= rxByte;
      end
    end
  end

  assign spiMosi = cmdShift[CMD_W-1];
  assign rdData  = dataReg;

  p_capture_after_sample_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureByte |-> $past(strb.sampleBit));

  p_no_shift_on_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |-> !strb.shiftBit && !strb.captureByte);

endmodule

// File: rtl/flash_rd_engine.sv
module flash_rd_engine
  import flash_rd_pkg::*;
#(
  parameter int NUM_CS = 2,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CS*CTL_W-1:0] ctlRegs,
  input  logic [NUM_CS-1:0]       addrFourByte,
  input  logic                    reqValid,
  input  logic [CS_W-1:0]         reqCs,
  input  logic [ADDR_W-1:0]       reqOffset,
  input  logic [1:0]              reqSize,
  output logic                    reqReady,
  output logic [DATA_W-1:0]       rdData,
  output logic                    rdDone,
  output logic [NUM_CS-1:0]       spiCsN,
  output logic                    spiSclk,
  output logic                    spiMosi,
  input  logic                    spiMiso
);

  logic [CTL_W-1:0] ctlArr [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ctl
    assign ctlArr[g] = ctlRegs[g*CTL_W +: CTL_W];
  end

  logic [CTL_W-1:0] selCtl;
  logic             selFour;
  logic [7:0]       selOpcode;
  logic [1:0]       selMode;
  logic [2:0]       selDummy;
  logic [GAP_W-1:0] selGap;
  logic             unusedCtlBits;

  assign selCtl        = ctlArr[reqCs];
  assign selFour       = addrFourByte[reqCs];
  assign selOpcode     = selCtl[OPC_LSB +: 8];
  assign selMode       = selCtl[MODE_LSB +: 2];
  assign selDummy      = {selCtl[DUMMY_HI_BIT], selCtl[DUMMY_LO_LSB +: 2]};
  assign selGap        = selCtl[GAP_LSB +: GAP_W];
  assign unusedCtlBits = ^{selCtl[31:28], selCtl[15], selCtl[13:8], selCtl[5:2]};

  dpStrobes_t strb;

  flash_rd_ctrl #(
    .NUM_CS(NUM_CS),
    .CS_W  (CS_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqCs   (reqCs),
    .reqSize (reqSize),
    .selMode (selMode),
    .selDummy(selDummy),
    .selGap  (selGap),
    .selFour (selFour),
    .reqReady(reqReady),
    .spiSclk (spiSclk),
    .spiCsN  (spiCsN),
    .rdDone  (rdDone),
    .strb    (strb)
  );

  flash_rd_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .opcode  (selOpcode),
    .fourByte(selFour),
    .offset  (reqOffset),
    .spiMiso (spiMiso),
    .spiMosi (spiMosi),
    .rdData  (rdData)
  );

endmodule

// File: tb/flash_rd_engine_bench.sv
module flash_rd_engine_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ctl0 = '0, ctl1 = '0;
  logic [1:0]  addrFourByte = '0;
  logic        reqValid = 1'b0;
  logic        reqCs = 1'b0;
  logic [31:0] reqOffset = '0;
  logic [1:0]  reqSize = '0;
  logic        reqReady, rdDone, spiSclk, spiMosi;
  logic        spiMiso = 1'b0;
  logic [31:0] rdData;
  logic [1:0]  spiCsN;

  always #5 clk = ~clk;

  flash_rd_engine #(.NUM_CS(2)) u_flash_rd_engine (
    .clk(clk), .rstN(rstN), .ctlRegs({ctl1, ctl0}), .addrFourByte(addrFourByte),
    .reqValid(reqValid), .reqCs(reqCs), .reqOffset(reqOffset), .reqSize(reqSize),
    .reqReady(reqReady), .rdData(rdData), .rdDone(rdDone), .spiCsN(spiCsN),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCtl(input logic [7:0] op, input logic [1:0] mode,
                                        input logic [2:0] dummy, input logic [3:0] inact);
    return {4'h0, inact, op, 1'b0, dummy[2], 6'h00, dummy[1:0], 4'h0, mode};
  endfunction

  logic [7:0] respSeed = 8'h00;

  function automatic logic [7:0] respByte(input logic [7:0] seed, input int idx);
    return seed ^ (8'h35 + 8'(idx * 29));
  endfunction

  // Flash model: logs bytes seen on spiMosi and serves a byte stream on spiMiso
  logic          anySel;
  logic [127:0]  mosiLog = '0;
  int            logBits = 0;
  int            outBit  = 0;
  logic [1:0]    selVec  = 2'b11;
  assign anySel = ~&spiCsN;

  always @(posedge anySel) begin
    mosiLog = '0;
    logBits = 0;
    outBit  = 0;
    selVec  = spiCsN;
    spiMiso = respByte(respSeed, 0)[7];
  end

  always @(posedge spiSclk) if (anySel) begin
    if (logBits < 128) mosiLog[127 - logBits] = spiMosi;
    logBits++;
    outBit++;
  end

  always @(negedge spiSclk) if (anySel) begin
    spiMiso = respByte(respSeed, outBit / 8)[7 - (outBit % 8)];
  end

  typedef struct {
    int           cs;
    int           nBytes;
    logic [127:0] mosi;
    logic [31:0]  data;
    string        tag;
  } expItem_t;

  expItem_t expQ[$];

  task automatic pushExp(input logic cs, input logic [31:0] off, input logic [1:0] size,
                         input string tag);
    expItem_t e;
    logic [31:0] c;
    int nA, nDum, nD;
    c    = cs ? ctl1 : ctl0;
    nA   = addrFourByte[cs] ? 4 : 3;
    nDum = (c[1:0] == 2'd1) ? int'({c[14], c[7:6]}) : 0;
    nD   = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    e.cs     = int'(cs);
    e.nBytes = 1 + nA + nDum + nD;
    e.mosi   = '0;
    e.mosi[127 -: 8] = c[23:16];
    for (int i = 0; i < nA; i++) e.mosi[119 - 8*i -: 8] = off[8*(nA-1-i) +: 8];
    e.data = '0;
    for (int j = 0; j < nD; j++) e.data[8*j +: 8] = respByte(off[7:0], 1 + nA + nDum + j);
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic drive(input logic cs, input logic [31:0] off, input logic [1:0] size,
                       input string tag);
    do @(negedge clk); while (!reqReady);
    pushExp(cs, off, size, tag);
    respSeed  = off[7:0];
    reqCs     = cs;
    reqOffset = off;
    reqSize   = size;
    reqValid  = 1'b1;
    @(negedge clk);
    reqValid  = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) if (rstN && rdDone) begin
    if (expQ.size() == 0) begin
      check(1'b0, "R8 unexpected done", 128'(rdData), 128'h0);
    end else begin
      expItem_t e;
      e = expQ.pop_front();
      check(rdData == e.data, {e.tag, " R7 R10 data"}, 128'(rdData), 128'(e.data));
      check(mosiLog == e.mosi && logBits == 8*e.nBytes,
            {e.tag, " R3 R4 R5 R6 byte stream"}, mosiLog, e.mosi);
      check(selVec == ~(2'b01 << e.cs) && spiCsN == 2'b11,
            {e.tag, " R2 R8 chip select"}, 128'({selVec, spiCsN}),
            128'({~(2'b01 << e.cs), 2'b11}));
      check(!reqReady, {e.tag, " R9 not ready in gap"}, 128'(reqReady), 128'h0);
    end
  end

  task automatic gapTest(input logic [3:0] inact, input string tag);
    int cnt;
    int expN;
    ctl0 = mkCtl(8'h03, 2'd0, 3'd0, inact);
    addrFourByte[0] = 1'b0;
    do @(negedge clk); while (!reqReady);
    pushExp(1'b0, 32'h0000_0040, 2'd0, {tag, " first"});
    pushExp(1'b0, 32'h0000_0040, 2'd0, {tag, " second"});
    respSeed  = 8'h40;
    reqCs     = 1'b0;
    reqOffset = 32'h0000_0040;
    reqSize   = 2'd0;
    reqValid  = 1'b1;
    do @(negedge clk); while (!rdDone);
    cnt = 0;
    while (spiCsN[0]) begin
      cnt++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    expN = 16 - int'(inact) + 1;
    check(cnt == expN, {tag, " R9 deselect length"}, 128'(cnt), 128'(expN));
    do @(negedge clk); while (!rdDone);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R8 watchdog expired", 128'h0, 128'h1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(spiCsN == 2'b11 && !spiSclk && !rdDone, "R1 in reset", 128'({spiCsN, spiSclk, rdDone}),
          128'({2'b11, 1'b0, 1'b0}));
    rstN = 1'b1;
    @(negedge clk);
    check(spiCsN == 2'b11 && !spiSclk && !spiMosi && !rdDone && reqReady,
          "R1 after reset", 128'({spiCsN, spiSclk, spiMosi, rdDone, reqReady}),
          128'({2'b11, 1'b0, 1'b0, 1'b0, 1'b1}));

    // plain read, 3-byte address drops offset top byte, count bits ignored (R4 R5 R6)
    ctl0 = mkCtl(8'h03, 2'd0, 3'd5, 4'hF);
    ctl1 = mkCtl(8'h0B, 2'd1, 3'd1, 4'hC);
    addrFourByte = 2'b10;
    drive(1'b0, 32'h12AB_CDEF, 2'd2, "T1 cs0 plain 3B size4");
    // fast read, 4-byte address, one dummy, one byte
    drive(1'b1, 32'h89AB_CD01, 2'd0, "T2 cs1 fast 4B dummy1 size1");
    // all dummy bits set: count 7, two bytes
    ctl1 = mkCtl(8'h0C, 2'd1, 3'd7, 4'h8);
    drive(1'b1, 32'h0102_0304, 2'd1, "T3 cs1 dummy7 size2");
    // only the high count bit (bit 14): count 4
    ctl0 = mkCtl(8'h5A, 2'd1, 3'd4, 4'hE);
    addrFourByte = 2'b00;
    drive(1'b0, 32'h0077_8899, 2'd2, "T4 cs0 dummy4 split field");
    // only the low count bits: count 2, 4-byte address, size code 3
    ctl0 = mkCtl(8'hA5, 2'd1, 3'd2, 4'hF);
    addrFourByte = 2'b01;
    drive(1'b0, 32'hF0E1_D2C3, 2'd3, "T5 cs0 dummy2 size3");
    // mode other than fast read with count bits set: no dummies
    ctl1 = mkCtl(8'h13, 2'd2, 3'd7, 4'hF);
    drive(1'b1, 32'h0000_5501, 2'd1, "T6 cs1 mode2 no dummy");

    gapTest(4'hF, "G1 field15");
    gapTest(4'h0, "G2 field0");
    gapTest(4'h9, "G3 field9");

    repeat (40) @(negedge clk);
    check(expQ.size() == 0, "R8 all reads completed", 128'(expQ.size()), 128'h0);
    check(spiCsN == 2'b11 && !spiSclk && !spiMosi && reqReady, "R1 R2 idle after traffic",
          128'({spiCsN, spiSclk, spiMosi, reqReady}), 128'({2'b11, 1'b0, 1'b0, 1'b1}));
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule